// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the left/right frame clock for a two-channel audio serial port, clocked from a master clock. In master mode it divides the master clock by 2 or 4 to form the bit clock, counts 32, 64 or 128 bit clocks per frame, and drives both clocks off-chip with an output enable. In slave mode the two clocks come from the external device. They are oversampled through a synchronizer and edge detector, and the block drives nothing.

In both modes the block gives a serializer the same timing view. A launch strobe marks the bit-clock edge on which data changes. A sample strobe marks the opposite edge. A frame-start strobe marks bit 0 of the left word. The block also presents a bit index and a channel flag. Configuration inputs set the bit-clock and frame-clock polarities and the divider ratios. A further input keeps the bit clock running while the port is idle, or stops it at its idle level. A global enable starts and stops everything and clears the counters, so the first frame after enable is always complete.

Top module: `aud_sclk_gen`

## Requirements
- R1: In master mode the bit-clock period is 2 master-clock cycles when `cfg_div_hi` is 0 and 4 cycles when it is 1. The bit clock has equal high and low halves. Exactly one launch strobe and one sample strobe occur per bit-clock period.
- R2: In master mode a frame lasts 32, 64 or 128 bit clocks for `cfg_frame_sel` codes 0, 1 and 2. Code 3 also selects 128.
- R3: Each frame holds exactly two channels, left first, each taking half the frame's bit clocks. `chan_right` is 1 during the right half. With `cfg_lr_inv` 0 the frame clock is low during the left word, and with `cfg_lr_inv` 1 it is high during the left word.
- R4: With `cfg_bclk_inv` 0, the launch strobe coincides with the bit clock going low and the sample strobe with it going high. With `cfg_bclk_inv` 1 both edges are reversed.
- R5: `clk_oe` is 1 in the cycle after `enable` and `cfg_master` are both 1, and 0 in the cycle after either is 0.
- R6: While `enable` is 0, the bit clock sits at `cfg_bclk_inv`, the frame clock sits at `cfg_lr_inv`, and no strobes occur. In the first cycle after `enable` rises in master mode, `frame_start` is 1 and `bit_idx` is 0.
- R7: In master mode with `cfg_free_run` 0 and `port_active` 0, the bit clock stays at its idle level and no strobes occur. When `port_active` rises, a complete frame starts in the next cycle.
- R8: `frame_start` is a one-cycle pulse that coincides with the launch strobe of bit 0 of the left word. At each launch strobe, `bit_idx` holds the position of the launched bit within the frame, counting from 0.
- R9: In slave mode, a launch-edge transition of `ext_bclk` gives a one-cycle `launch_stb`. The pulse is visible SYNC_STAGES+1 master-clock cycles after the transition, which is 3 cycles by default.
- R10: In slave mode, a frame starts at the first launch edge after the external frame clock moves from the right-word level to the left-word level. The bit index restarts at 0 there, and the frame length follows the external clocks.
- R11: While `rst_n` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable; low stops both clocks and clears the counters |
| cfg_div_hi | input | 1 | Master-to-bit-clock ratio: 0 gives 2, 1 gives 4 |
| cfg_frame_sel | input | 2 | Bit clocks per frame: 0 gives 32, 1 gives 64, 2 or 3 gives 128 |
| cfg_bclk_inv | input | 1 | Bit-clock polarity |
| cfg_lr_inv | input | 1 | Frame-clock polarity |
| cfg_master | input | 1 | 1: drive both clocks; 0: take them from outside |
| cfg_free_run | input | 1 | 1: bit clock runs continuously; 0: it stops while the port is idle |
| port_active | input | 1 | Port has data to move (used for gating) |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_lrclk | input | 1 | External frame clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock |
| lrclk_out | output | 1 | Generated frame clock |
| clk_oe | output | 1 | Output enable for the two clock pins |
| launch_stb | output | 1 | Data-change edge strobe |
| sample_stb | output | 1 | Data-capture edge strobe |
| frame_start | output | 1 | Launch of bit 0 of the left word |
| chan_right | output | 1 | Current bit belongs to the right word |
| bit_idx | output | IDX_W | Bit position within the frame |

## Verification
The assertions assume two things about the inputs. First, the configuration inputs change only while `enable` is low. Second, in slave mode each level of the external clocks lasts longer than the synchronizer depth, so no edge is lost. The stimulus meets both. It reprograms every field with the enable low and waits several cycles before raising it again. In slave mode it drives each external bit-clock level for four master-clock cycles and changes the external frame clock only together with a launch edge.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;

   // log2 of the shortest frame, in bit clocks
   localparam int unsigned FRAME_BASE_LOG2 = 5;

   typedef enum logic [1:0] {
      FRM_SHORT  = 2'd0,
      FRM_MID    = 2'd1,
      FRM_LONG   = 2'd2,
      FRM_LONG_B = 2'd3
   } frame_sel_e;

   // Code 3 aliases the longest frame.
   function automatic int unsigned frame_len_log2(input logic [1:0] sel);
      int unsigned ext;
      ext = (sel == FRM_LONG_B) ? 2 : int'(sel);
      return FRAME_BASE_LOG2 + ext;
   endfunction

endpackage

// File: rtl/aud_clk_prescale.sv
module aud_clk_prescale #(
   parameter int unsigned DIV_LO = 2,
   parameter int unsigned DIV_HI = 4,
   localparam int unsigned CNT_W = (DIV_HI > 2) ? $clog2(DIV_HI) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             div_hi,
   output logic [CNT_W-1:0] cnt_q,
   output logic             period_end,
   output logic             launch,
   output logic             sample,
   output logic             phase_hi
);

   generate
      if ((DIV_LO < 2) || (DIV_LO % 2 != 0) || (DIV_HI % 2 != 0) || (DIV_HI < DIV_LO)) begin : g_bad_div
         $error("aud_clk_prescale: divider ratios must be even, at least 2, with DIV_HI >= DIV_LO");
      end
   endgenerate

   logic [CNT_W-1:0] last_v;
   logic [CNT_W-1:0] half_v;

   assign last_v = div_hi ? CNT_W'(DIV_HI - 1) : CNT_W'(DIV_LO - 1);
   assign half_v = div_hi ? CNT_W'(DIV_HI / 2) : CNT_W'(DIV_LO / 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (cnt_q >= last_v) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign period_end = run && (cnt_q >= last_v);
   assign launch     = run && (cnt_q == '0);
   assign sample     = run && (cnt_q == half_v);
   assign phase_hi   = (cnt_q >= half_v);

   // R1: the prescaler restarts a bit period after the last phase
   a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |=> (cnt_q == '0));

endmodule

// File: rtl/aud_clk_framer.sv
module aud_clk_framer import aud_clk_pkg::*; #(
   parameter int unsigned IDX_W = FRAME_BASE_LOG2 + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [1:0]       frame_sel,
   input  logic             period_end,
   output logic [IDX_W-1:0] bit_cnt,
   output logic             right
);

   generate
      if (IDX_W < FRAME_BASE_LOG2 + 2) begin : g_bad_idx
         $error("aud_clk_framer: IDX_W too narrow for the longest frame");
      end
   endgenerate

   logic [IDX_W-1:0] len_m1;
   logic [IDX_W-1:0] half_len;

   always_comb begin
      len_m1   = IDX_W'((32'd1 << frame_len_log2(frame_sel)) - 32'd1);
      half_len = IDX_W'(32'd1 << (frame_len_log2(frame_sel) - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
      end else if (!run) begin
         bit_cnt <= '0;
      end else if (period_end) begin
         if (bit_cnt >= len_m1) begin
            bit_cnt <= '0;
         end else begin
            bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   assign right = (bit_cnt >= half_len);

   // R2: after the last bit of a frame the count restarts at bit 0
   a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (period_end && (bit_cnt == len_m1)) |=> (bit_cnt == '0));

endmodule

// File: rtl/aud_clk_slave_sync.sv
module aud_clk_slave_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ext_bclk,
   input  logic ext_lr,
   input  logic bclk_inv,
   input  logic lr_inv,
   output logic launch,
   output logic sample,
   output logic lr_norm
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("aud_clk_slave_sync: at least two synchronizer stages required");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] b_sync;
   logic [SYNC_STAGES-1:0] l_sync;
   logic                   b_prev;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  b_sync[0] <= 1'b0;
                  l_sync[0] <= 1'b0;
               end else begin
                  b_sync[0] <= ext_bclk;
                  l_sync[0] <= ext_lr;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  b_sync[gi] <= 1'b0;
                  l_sync[gi] <= 1'b0;
               end else begin
                  b_sync[gi] <= b_sync[gi-1];
                  l_sync[gi] <= l_sync[gi-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_prev <= 1'b0;
      end else begin
         b_prev <= b_sync[SYNC_STAGES-1];
      end
   end

   logic b_now_n;
   logic b_old_n;

   assign b_now_n = b_sync[SYNC_STAGES-1] ^ bclk_inv;
   assign b_old_n = b_prev ^ bclk_inv;
   assign launch  = en && b_old_n && !b_now_n;
   assign sample  = en && !b_old_n && b_now_n;
   assign lr_norm = l_sync[SYNC_STAGES-1] ^ lr_inv;

   // R9: each detected launch edge yields a single-cycle strobe
   a_r9_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !launch);

endmodule

// File: rtl/aud_sclk_gen.sv
module aud_sclk_gen import aud_clk_pkg::*; #(
   parameter int unsigned DIV_LO      = 2,
   parameter int unsigned DIV_HI      = 4,
   parameter int unsigned IDX_W       = FRAME_BASE_LOG2 + 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             cfg_div_hi,
   input  logic [1:0]       cfg_frame_sel,
   input  logic             cfg_bclk_inv,
   input  logic             cfg_lr_inv,
   input  logic             cfg_master,
   input  logic             cfg_free_run,
   input  logic             port_active,
   input  logic             ext_bclk,
   input  logic             ext_lrclk,
   output logic             bclk_out,
   output logic             lrclk_out,
   output logic             clk_oe,
   output logic             launch_stb,
   output logic             sample_stb,
   output logic             frame_start,
   output logic             chan_right,
   output logic [IDX_W-1:0] bit_idx
);

   localparam int unsigned PRE_W = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;

   // ---------------- master path ----------------
   logic             run_m;
   logic [PRE_W-1:0] pre_cnt;
   logic             m_pend;
   logic             m_launch;
   logic             m_sample;
   logic             m_phase_hi;
   logic [IDX_W-1:0] m_cnt;
   logic             m_right;

   assign run_m = enable && cfg_master && (cfg_free_run || port_active);

   aud_clk_prescale #(
      .DIV_LO (DIV_LO),
      .DIV_HI (DIV_HI)
   ) u_pre (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_m),
      .div_hi     (cfg_div_hi),
      .cnt_q      (pre_cnt),
      .period_end (m_pend),
      .launch     (m_launch),
      .sample     (m_sample),
      .phase_hi   (m_phase_hi)
   );

   aud_clk_framer #(
      .IDX_W (IDX_W)
   ) u_frm (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_m),
      .frame_sel  (cfg_frame_sel),
      .period_end (m_pend),
      .bit_cnt    (m_cnt),
      .right      (m_right)
   );

   // ---------------- slave path ----------------
   logic             slv_en;
   logic             s_launch;
   logic             s_sample;
   logic             s_lr;
   logic             s_lr_last;
   logic [IDX_W-1:0] s_cnt;
   logic             s_lr_fall;
   logic [IDX_W-1:0] s_next;

   assign slv_en = enable && !cfg_master;

   aud_clk_slave_sync #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (slv_en),
      .ext_bclk (ext_bclk),
      .ext_lr   (ext_lrclk),
      .bclk_inv (cfg_bclk_inv),
      .lr_inv   (cfg_lr_inv),
      .launch   (s_launch),
      .sample   (s_sample),
      .lr_norm  (s_lr)
   );

   assign s_lr_fall = s_lr_last && !s_lr;
   assign s_next    = s_lr_fall ? '0 : (s_cnt + 1'b1);

   // s_cnt idles at all-ones so the first launch after enable reports bit 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_cnt     <= '1;
         s_lr_last <= 1'b0;
      end else if (!slv_en) begin
         s_cnt     <= '1;
         s_lr_last <= 1'b0;
      end else if (s_launch) begin
         s_cnt     <= s_next;
         s_lr_last <= s_lr;
      end
   end

   // ---------------- output stage ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_out    <= 1'b0;
         lrclk_out   <= 1'b0;
         clk_oe      <= 1'b0;
         launch_stb  <= 1'b0;
         sample_stb  <= 1'b0;
         frame_start <= 1'b0;
         chan_right  <= 1'b0;
         bit_idx     <= '0;
      end else begin
         clk_oe <= enable && cfg_master;
         if (cfg_master) begin
            bclk_out    <= run_m ? (m_phase_hi ^ cfg_bclk_inv) : cfg_bclk_inv;
            lrclk_out   <= run_m ? (m_right ^ cfg_lr_inv) : cfg_lr_inv;
            launch_stb  <= m_launch;
            sample_stb  <= m_sample;
            frame_start <= m_launch && (m_cnt == '0);
            chan_right  <= run_m && m_right;
            bit_idx     <= run_m ? m_cnt : '0;
         end else begin
            bclk_out    <= cfg_bclk_inv;
            lrclk_out   <= cfg_lr_inv;
            launch_stb  <= s_launch;
            sample_stb  <= s_sample;
            frame_start <= s_launch && s_lr_fall;
            chan_right  <= slv_en && s_lr;
            if (!slv_en) begin
               bit_idx <= '0;
            end else if (s_launch) begin
               bit_idx <= s_next;
            end
         end
      end
   end

   // R5: pin drivers follow master mode and enable
   a_r5_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && cfg_master) |=> clk_oe);
   a_r5_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
      !(enable && cfg_master) |=> !clk_oe);

   // R6: disabled port parks both clocks at their idle levels, no strobes
   a_r6_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> ((bclk_out == $past(cfg_bclk_inv)) && (lrclk_out == $past(cfg_lr_inv))
                   && !launch_stb && !sample_stb));

   // R7: gated and idle means a quiet bit clock
   a_r7_gated_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && cfg_master && !cfg_free_run && !port_active)
        |=> (!launch_stb && (bclk_out == $past(cfg_bclk_inv))));

   // R8: frame start marks bit 0 of the left word on a launch edge
   a_r8_fs_left_bit0: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> ((bit_idx == '0) && !chan_right && launch_stb));

endmodule

// File: tb/aud_sclk_gen_tb.sv
module aud_sclk_gen_tb;

   localparam int IDX_W = 7;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic             cfg_div_hi = 1'b0;
   logic [1:0]       cfg_frame_sel = 2'd0;
   logic             cfg_bclk_inv = 1'b0;
   logic             cfg_lr_inv = 1'b0;
   logic             cfg_master = 1'b1;
   logic             cfg_free_run = 1'b1;
   logic             port_active = 1'b0;
   logic             ext_bclk = 1'b0;
   logic             ext_lrclk = 1'b0;
   logic             bclk_out;
   logic             lrclk_out;
   logic             clk_oe;
   logic             launch_stb;
   logic             sample_stb;
   logic             frame_start;
   logic             chan_right;
   logic [IDX_W-1:0] bit_idx;

   always #2 clk = ~clk;

   aud_sclk_gen u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .cfg_div_hi    (cfg_div_hi),
      .cfg_frame_sel (cfg_frame_sel),
      .cfg_bclk_inv  (cfg_bclk_inv),
      .cfg_lr_inv    (cfg_lr_inv),
      .cfg_master    (cfg_master),
      .cfg_free_run  (cfg_free_run),
      .port_active   (port_active),
      .ext_bclk      (ext_bclk),
      .ext_lrclk     (ext_lrclk),
      .bclk_out      (bclk_out),
      .lrclk_out     (lrclk_out),
      .clk_oe        (clk_oe),
      .launch_stb    (launch_stb),
      .sample_stb    (sample_stb),
      .frame_start   (frame_start),
      .chan_right    (chan_right),
      .bit_idx       (bit_idx)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // vector fields: [4] div_hi, [3:2] frame_sel, [1] bclk_inv, [0] lr_inv
   localparam logic [4:0] VEC [7] = '{
      5'b0_00_0_0, 5'b1_00_0_0, 5'b0_01_1_0, 5'b1_01_0_1,
      5'b0_10_1_1, 5'b1_10_0_0, 5'b1_11_1_0
   };

   // slave-mode monitor
   logic mon_en = 1'b0;
   int   mon_l, mon_fs, mon_bad, mon_max, mon_r;
   always @(negedge clk) begin
      if (!mon_en) begin
         mon_l = 0; mon_fs = 0; mon_bad = 0; mon_max = 0; mon_r = 0;
      end else begin
         if (launch_stb) begin
            mon_l++;
            if (chan_right) mon_r++;
            if (int'(bit_idx) > mon_max) mon_max = int'(bit_idx);
         end
         if (frame_start) begin
            mon_fs++;
            if ((bit_idx != '0) || chan_right) mon_bad++;
         end
      end
   end

   task automatic run_master(input logic [4:0] v);
      int d, n, cyc, lau, smp, rlau, hi, bad;
      d = v[4] ? 4 : 2;
      n = 32 << ((v[3:2] == 2'd3) ? 2 : int'(v[3:2]));
      enable = 1'b0;
      @(negedge clk);
      cfg_master = 1'b1; cfg_free_run = 1'b1;
      cfg_div_hi = v[4]; cfg_frame_sel = v[3:2];
      cfg_bclk_inv = v[1]; cfg_lr_inv = v[0];
      repeat (3) @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      chk("R6", "first frame_start after enable", int'(frame_start), 1);
      cyc = 0; lau = 0; smp = 0; rlau = 0; hi = 0; bad = 0;
      do begin
         if ((bclk_out ^ v[1]) == 1'b1) hi++;
         if (launch_stb) begin
            if ((bclk_out ^ v[1]) != 1'b0) bad++;             // R4
            if (lrclk_out != (chan_right ^ v[0])) bad++;      // R3
            if (int'(bit_idx) != lau) bad++;                  // R8
            if (chan_right != (lau >= n / 2)) bad++;          // R3
            if (chan_right) rlau++;
            lau++;
         end
         if (sample_stb) begin
            smp++;
            if ((bclk_out ^ v[1]) != 1'b1) bad++;             // R4
         end
         @(negedge clk);
         cyc++;
      end while (!frame_start && cyc < 5000);
      chk("R1", "cycles per frame", cyc, d * n);
      chk("R1", "bclk high cycles", hi, d * n / 2);
      chk("R2", "launches per frame", lau, n);
      chk("R1", "samples per frame", smp, n);
      chk("R3", "right-word launches", rlau, n / 2);
      chk("R4", "edge/level/index mismatches", bad, 0);
   endtask

   task automatic slave_frames(input logic binv, input logic linv);
      enable = 1'b0;
      @(negedge clk);
      cfg_master = 1'b0; cfg_bclk_inv = binv; cfg_lr_inv = linv;
      ext_bclk = ~binv; ext_lrclk = linv;
      repeat (6) @(negedge clk);
      enable = 1'b1; mon_en = 1'b1;
      for (int f = 0; f < 3; f++) begin
         for (int b = 0; b < 32; b++) begin
            ext_lrclk = (b >= 16) ^ linv;
            ext_bclk  = binv;
            repeat (4) @(negedge clk);
            ext_bclk  = ~binv;
            repeat (4) @(negedge clk);
         end
      end
      repeat (6) @(negedge clk);
      chk("R10", "slave launches", mon_l, 96);
      chk("R10", "slave frame starts", mon_fs, 2);
      chk("R10", "slave frame_start at bad index", mon_bad, 0);
      chk("R10", "slave max bit index", mon_max, 31);
      chk("R10", "slave right-word launches", mon_r, 48);
      chk("R5", "clk_oe in slave mode", int'(clk_oe), 0);
      mon_en = 1'b0;
      enable = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int cnt;
      // R11 reset state
      repeat (3) @(negedge clk);
      chk("R11", "reset outputs", int'({bclk_out, lrclk_out, clk_oe, launch_stb,
                                        sample_stb, frame_start, chan_right}), 0);
      chk("R11", "reset bit_idx", int'(bit_idx), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // main vector table
      foreach (VEC[i]) begin
         run_master(VEC[i]);
      end

      // R5 output enable in master mode
      chk("R5", "clk_oe in master mode", int'(clk_oe), 1);

      // R6 disable parks clocks (inverted polarities)
      enable = 1'b0;
      @(negedge clk);
      cfg_bclk_inv = 1'b1; cfg_lr_inv = 1'b1;
      @(negedge clk);
      chk("R6", "idle bclk level", int'(bclk_out), 1);
      chk("R6", "idle lrclk level", int'(lrclk_out), 1);
      chk("R5", "clk_oe after disable", int'(clk_oe), 0);
      cnt = 0;
      repeat (20) begin
         @(negedge clk);
         if (launch_stb || sample_stb) cnt++;
      end
      chk("R6", "strobes while disabled", cnt, 0);

      // R7 gating
      cfg_bclk_inv = 1'b0; cfg_lr_inv = 1'b0; cfg_div_hi = 1'b1; cfg_frame_sel = 2'd0;
      cfg_free_run = 1'b0; port_active = 1'b0;
      @(negedge clk);
      enable = 1'b1;
      cnt = 0;
      repeat (40) begin
         @(negedge clk);
         if (launch_stb || bclk_out) cnt++;
      end
      chk("R7", "gated bclk activity", cnt, 0);
      port_active = 1'b1;
      @(negedge clk);
      chk("R7", "frame_start after port_active", int'(frame_start), 1);
      chk("R7", "bit_idx after port_active", int'(bit_idx), 0);
      cnt = 0;
      repeat (16) begin
         @(negedge clk);
         if (launch_stb) cnt++;
      end
      chk("R7", "launches after ungating", cnt, 4);
      enable = 1'b0; port_active = 1'b0; cfg_free_run = 1'b1;
      @(negedge clk);

      // R9 slave synchronizer latency
      cfg_master = 1'b0; cfg_bclk_inv = 1'b0; ext_bclk = 1'b1; ext_lrclk = 1'b0;
      repeat (6) @(negedge clk);
      enable = 1'b1;
      repeat (4) @(negedge clk);
      ext_bclk = 1'b0;
      @(negedge clk);
      chk("R9", "launch at +1", int'(launch_stb), 0);
      @(negedge clk);
      chk("R9", "launch at +2", int'(launch_stb), 0);
      @(negedge clk);
      chk("R9", "launch at +3", int'(launch_stb), 1);
      @(negedge clk);
      chk("R9", "launch at +4", int'(launch_stb), 0);
      enable = 1'b0;
      @(negedge clk);

      // R10 slave framing, both polarity settings
      slave_frames(1'b0, 1'b0);
      slave_frames(1'b1, 1'b1);

      finish_run();
   end

endmodule